// File: doc/BRIEF.md
# Precise Interrupt and Exception Controller

This block sits beside the commit point of a simple in-order core and decides, for each instruction offered for retirement, whether that instruction completes or whether control is diverted to the trap handler. It takes two kinds of event. The first is a set of prioritised interrupt request lines, each gated by its own mask bit and latched into a pending register. The second is a synchronous cause that the core reports with the retiring instruction. Everything older than the instruction at the commit point has already retired, so that instruction either retires or becomes the saved return point. This keeps the event precise.

When an event is taken, the block holds back the retiring instruction and saves its PC as the exception return address. It records a 4-bit cause code that the handler can read. It pushes the current mode and interrupt-enable bit into a one-level save slot, then enters kernel mode with interrupts off and redirects fetch to a single handler vector. A system call is the exception to this: the instruction counts as completed and the return address is the next instruction. A return-from-exception command issued in kernel mode restores mode and enable from the save slot in one step and redirects fetch to the saved address.

Top module: `evt_ctrl`

## Requirements
- R1: After reset the block is in kernel mode with interrupts disabled. EPC, cause and pending bits are zero, every mask bit is one (line enabled), and no redirect is asserted.
- R2: A high level on an interrupt line sets its pending bit at the next clock edge. A pending bit stays set while interrupts are disabled or the line is masked, and is cleared only when that line's interrupt is taken.
- R3: Suppose an instruction retires with interrupts enabled, no synchronous cause, and at least one line both pending and unmasked. The block then redirects to the handler vector in the same cycle and holds the instruction back (commit_ok low). On the next edge EPC holds that instruction's PC and the cause holds the line index (0 to 7). The lowest-indexed eligible line wins.
- R4: Mask bit i set to 1 enables line i, and a masked pending line is never taken. A mask write takes effect only in kernel mode. In user mode it is ignored and the mask keeps its value.
- R5: A synchronous cause is encoded on sync_kind as 0 undefined opcode, 1 privileged instruction, 2 arithmetic overflow, 3 misaligned access, 4 page fault, 5 protection violation, 6 system call, and 7 reserved. Kinds 0 to 5 give cause 8 plus the kind. Kind 7 gives cause 8. For all of these the instruction is held back, EPC receives its PC, and fetch is redirected to the handler vector.
- R6: A system call (kind 6) gives cause 14 and retires (commit_ok high). EPC receives the PC plus the instruction size, wrapping modulo 2^XLEN.
- R7: A synchronous cause takes priority over interrupts in the same cycle, and the interrupt stays pending.
- R8: Any taken event clears the interrupt enable, enters kernel mode, and saves the previous enable and mode into the save slot.
- R9: A return-from-exception in kernel mode redirects to EPC in the same cycle and retires. On the next edge it restores enable and mode from the save slot.
- R10: A return-from-exception attempted in user mode is a privileged-instruction fault (cause 9), with no state restored.
- R11: With no valid retiring instruction nothing is taken and no redirect is asserted, even if an eligible interrupt is pending.
- R12: The save slot resets to user mode with interrupts enabled, so the first return-from-exception after reset drops to user mode with interrupts on, at EPC 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_IRQ | Interrupt request levels, bit 0 highest priority |
| mask_wr | input | 1 | Mask write strobe (kernel mode only) |
| mask_wdata | input | NUM_IRQ | New mask value, 1 enables a line |
| retire_valid | input | 1 | An instruction is at the commit point |
| retire_pc | input | XLEN | PC of that instruction |
| sync_valid | input | 1 | The instruction raises a synchronous cause |
| sync_kind | input | 3 | Synchronous cause kind (see R5) |
| rfe_cmd | input | 1 | The instruction is a return-from-exception |
| redirect | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Handler vector or EPC |
| commit_ok | output | 1 | The retiring instruction completes |
| kernel_mode | output | 1 | Current privilege, 1 is kernel |
| int_enable | output | 1 | Global interrupt enable |
| epc | output | XLEN | Saved return address |
| cause | output | 4 | Cause of the last taken event |
| irq_pending | output | NUM_IRQ | Latched pending lines |
| irq_mask | output | NUM_IRQ | Current mask |

## Verification
The bench builds the block with XLEN of 16, four interrupt lines and a handler vector of 0x0080. The narrow PC lets a system call at 0xFFFC show the return address wrapping to zero. With four lines, the top line and the lowest-index priority are both reachable in short directed runs. The small vector also keeps redirect targets easy to tell apart from EPC values.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int CAUSE_W = 4;
  localparam int IDX_W   = 3;
  typedef logic [CAUSE_W-1:0] cause_t;

  typedef enum logic [2:0] {
    SK_UNDEF   = 3'd0,
    SK_PRIV    = 3'd1,
    SK_OVF     = 3'd2,
    SK_MISAL   = 3'd3,
    SK_PGFLT   = 3'd4,
    SK_PROT    = 3'd5,
    SK_SYSCALL = 3'd6,
    SK_RSVD    = 3'd7
  } sync_kind_e;

  localparam cause_t SYNC_BASE = 4'd8;

  // Synchronous kind to cause code; reserved kind folds onto undefined opcode
  function automatic cause_t sync_cause(input logic [2:0] kind);
    if (kind == SK_RSVD) return SYNC_BASE;
    return SYNC_BASE + cause_t'({1'b0, kind});
  endfunction

  function automatic cause_t irq_cause(input logic [IDX_W-1:0] idx);
    return {1'b0, idx};
  endfunction

  function automatic logic is_syscall(input logic [2:0] kind);
    return kind == SK_SYSCALL;
  endfunction
endpackage

// File: rtl/evt_irq_arb.sv
module evt_irq_arb #(
  parameter int NUM_IRQ = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_lines,
  input  logic                       mask_we,
  input  logic [NUM_IRQ-1:0]         mask_wdata,
  input  logic                       clr_en,
  output logic [NUM_IRQ-1:0]         pending,
  output logic [NUM_IRQ-1:0]         mask,
  output logic                       any_req,
  output logic [evt_pkg::IDX_W-1:0]  sel_idx
);
  import evt_pkg::*;

  logic [NUM_IRQ-1:0] eligible;
  logic [NUM_IRQ-1:0] clr_vec;

  assign eligible = pending & mask;
  assign any_req  = |eligible;

  // Fixed priority: lowest index wins
  always_comb begin
    sel_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (eligible[i]) sel_idx = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_clr
    assign clr_vec[g] = clr_en && (sel_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      mask    <= '1;
    end else begin
      pending <= (pending & ~clr_vec) | irq_lines;
      if (mask_we) mask <= mask_wdata;
    end
  end
endmodule

// File: rtl/evt_decide.sv
module evt_decide (
  input  logic                      retire_valid,
  input  logic                      sync_valid,
  input  logic [2:0]                sync_kind,
  input  logic                      rfe_cmd,
  input  logic                      mask_req,
  input  logic                      int_enable,
  input  logic                      kernel_mode,
  input  logic                      any_req,
  input  logic [evt_pkg::IDX_W-1:0] sel_idx,
  output logic                      take_sync,
  output logic                      take_irq,
  output logic                      take_any,
  output logic                      syscall_take,
  output logic                      do_rfe,
  output logic                      mask_we,
  output logic                      commit_ok,
  output evt_pkg::cause_t           cause_next
);
  import evt_pkg::*;

  logic   rfe_priv;
  cause_t sync_code;

  assign rfe_priv  = rfe_cmd && !kernel_mode;
  assign sync_code = sync_valid ? sync_cause(sync_kind) : (SYNC_BASE + cause_t'(SK_PRIV));

  // Priority: synchronous cause, then interrupt, then return-from-exception
  assign take_sync    = retire_valid && (sync_valid || rfe_priv);
  assign take_irq     = retire_valid && !take_sync && int_enable && any_req;
  assign take_any     = take_sync || take_irq;
  assign syscall_take = take_sync && sync_valid && is_syscall(sync_kind);
  assign do_rfe       = retire_valid && rfe_cmd && kernel_mode && !take_any;
  assign mask_we      = mask_req && kernel_mode;
  assign commit_ok    = retire_valid && (!take_any || syscall_take);
  assign cause_next   = take_sync ? sync_code : irq_cause(sel_idx);
endmodule

// File: rtl/evt_state.sv
module evt_state #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_any,
  input  logic            syscall_take,
  input  logic            do_rfe,
  input  evt_pkg::cause_t cause_next,
  input  logic [XLEN-1:0] retire_pc,
  output logic [XLEN-1:0] epc,
  output evt_pkg::cause_t cause,
  output logic            int_enable,
  output logic            kernel_mode,
  output logic            saved_ie,
  output logic            saved_km
);
  import evt_pkg::*;

  // Restart point: faulting instruction itself, or the next one for a trap
  function automatic logic [XLEN-1:0] return_point(input logic [XLEN-1:0] pc, input logic trap);
    return trap ? pc + XLEN'(INSN_BYTES) : pc;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc         <= '0;
      cause       <= '0;
      int_enable  <= 1'b0;
      kernel_mode <= 1'b1;
      saved_ie    <= 1'b1;
      saved_km    <= 1'b0;
    end else if (take_any) begin
      epc         <= return_point(retire_pc, syscall_take);
      cause       <= cause_next;
      saved_ie    <= int_enable;
      saved_km    <= kernel_mode;
      int_enable  <= 1'b0;
      kernel_mode <= 1'b1;
    end else if (do_rfe) begin
      int_enable  <= saved_ie;
      kernel_mode <= saved_km;
    end
  end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl #(
  parameter int              XLEN        = 32,
  parameter int              NUM_IRQ     = 8,
  parameter int              INSN_BYTES  = 4,
  parameter logic [XLEN-1:0] HANDLER_VEC = XLEN'(32'h0000_0100)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               mask_wr,
  input  logic [NUM_IRQ-1:0] mask_wdata,
  input  logic               retire_valid,
  input  logic [XLEN-1:0]    retire_pc,
  input  logic               sync_valid,
  input  logic [2:0]         sync_kind,
  input  logic               rfe_cmd,
  output logic               redirect,
  output logic [XLEN-1:0]    redirect_pc,
  output logic               commit_ok,
  output logic               kernel_mode,
  output logic               int_enable,
  output logic [XLEN-1:0]    epc,
  output logic [3:0]         cause,
  output logic [NUM_IRQ-1:0] irq_pending,
  output logic [NUM_IRQ-1:0] irq_mask
);
  import evt_pkg::*;

  logic               take_sync, take_irq, take_any, syscall_take, do_rfe, mask_we;
  logic               any_req, saved_ie, saved_km;
  logic [IDX_W-1:0]   sel_idx;
  cause_t             cause_next, cause_q;

  evt_irq_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lines  (irq_lines),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .clr_en     (take_irq),
    .pending    (irq_pending),
    .mask       (irq_mask),
    .any_req    (any_req),
    .sel_idx    (sel_idx)
  );

  evt_decide u_dec (
    .retire_valid (retire_valid),
    .sync_valid   (sync_valid),
    .sync_kind    (sync_kind),
    .rfe_cmd      (rfe_cmd),
    .mask_req     (mask_wr),
    .int_enable   (int_enable),
    .kernel_mode  (kernel_mode),
    .any_req      (any_req),
    .sel_idx      (sel_idx),
    .take_sync    (take_sync),
    .take_irq     (take_irq),
    .take_any     (take_any),
    .syscall_take (syscall_take),
    .do_rfe       (do_rfe),
    .mask_we      (mask_we),
    .commit_ok    (commit_ok),
    .cause_next   (cause_next)
  );

  evt_state #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_any     (take_any),
    .syscall_take (syscall_take),
    .do_rfe       (do_rfe),
    .cause_next   (cause_next),
    .retire_pc    (retire_pc),
    .epc          (epc),
    .cause        (cause_q),
    .int_enable   (int_enable),
    .kernel_mode  (kernel_mode),
    .saved_ie     (saved_ie),
    .saved_km     (saved_km)
  );

  assign cause       = cause_q;
  assign redirect    = take_any || do_rfe;
  assign redirect_pc = take_any ? HANDLER_VEC : epc;
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk #(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               retire_valid,
  input logic               sync_valid,
  input logic               rfe_cmd,
  input logic [XLEN-1:0]    retire_pc,
  input logic               take_any,
  input logic               take_sync,
  input logic               take_irq,
  input logic               do_rfe,
  input logic               syscall_take,
  input logic               commit_ok,
  input logic               redirect,
  input logic               int_enable,
  input logic               kernel_mode,
  input logic               saved_ie,
  input logic               saved_km,
  input logic [XLEN-1:0]    epc,
  input logic [3:0]         cause,
  input logic [NUM_IRQ-1:0] pending,
  input logic [NUM_IRQ-1:0] mask
);
  p_pending_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !int_enable |=> (pending & $past(pending)) == $past(pending));

  p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> int_enable && ((pending & mask) != '0));

  p_mask_locked_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !kernel_mode |=> mask == $past(mask));

  p_fault_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_any && !syscall_take |-> !commit_ok);

  p_epc_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_any && !syscall_take |=> epc == $past(retire_pc));

  p_sync_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && sync_valid |-> take_sync && !take_irq);

  p_take_enters_kernel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_any |=> kernel_mode && !int_enable);

  p_take_saves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_any |=> saved_ie == $past(int_enable) && saved_km == $past(kernel_mode));

  p_rfe_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_rfe |=> int_enable == $past(saved_ie) && kernel_mode == $past(saved_km));

  p_user_rfe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && rfe_cmd && !kernel_mode && !sync_valid |=> cause == 4'd9);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_valid |-> !redirect);
endmodule

bind evt_ctrl evt_ctrl_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .retire_valid (retire_valid),
  .sync_valid   (sync_valid),
  .rfe_cmd      (rfe_cmd),
  .retire_pc    (retire_pc),
  .take_any     (take_any),
  .take_sync    (take_sync),
  .take_irq     (take_irq),
  .do_rfe       (do_rfe),
  .syscall_take (syscall_take),
  .commit_ok    (commit_ok),
  .redirect     (redirect),
  .int_enable   (int_enable),
  .kernel_mode  (kernel_mode),
  .saved_ie     (saved_ie),
  .saved_km     (saved_km),
  .epc          (epc),
  .cause        (cause),
  .pending      (irq_pending),
  .mask         (irq_mask)
);

// File: tb/tb_evt_ctrl.sv
module tb_evt_ctrl;
  localparam int          XLEN = 16;
  localparam int          NIRQ = 4;
  localparam logic [15:0] VEC  = 16'h0080;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NIRQ-1:0] irq_lines = '0, mask_wdata = '0, irq_pending, irq_mask;
  logic            mask_wr = 1'b0, retire_valid = 1'b0, sync_valid = 1'b0, rfe_cmd = 1'b0;
  logic [XLEN-1:0] retire_pc = '0, redirect_pc, epc;
  logic [2:0]      sync_kind = '0;
  logic            redirect, commit_ok, kernel_mode, int_enable;
  logic [3:0]      cause;
  int              n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  evt_ctrl #(.XLEN(XLEN), .NUM_IRQ(NIRQ), .INSN_BYTES(4), .HANDLER_VEC(VEC)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .sync_valid(sync_valid), .sync_kind(sync_kind), .rfe_cmd(rfe_cmd),
    .redirect(redirect), .redirect_pc(redirect_pc), .commit_ok(commit_ok),
    .kernel_mode(kernel_mode), .int_enable(int_enable), .epc(epc), .cause(cause),
    .irq_pending(irq_pending), .irq_mask(irq_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    #2;
    irq_lines = '0; mask_wr = 1'b0; mask_wdata = '0; retire_valid = 1'b0;
    sync_valid = 1'b0; sync_kind = '0; rfe_cmd = 1'b0; retire_pc = '0;
  endtask

  task automatic retire(input logic [15:0] pc, input logic sv, input logic [2:0] k, input logic rfe);
    retire_valid = 1'b1; retire_pc = pc; sync_valid = sv; sync_kind = k; rfe_cmd = rfe;
    #1;
  endtask

  task automatic do_rfe();
    retire(16'h00F0, 1'b0, 3'd0, 1'b1);
    adv();
  endtask

  task automatic t_reset();
    chk("R1 kernel", kernel_mode, 1);
    chk("R1 ie", int_enable, 0);
    chk("R1 cause", cause, 0);
    chk("R1 epc", epc, 0);
    chk("R1 pending", irq_pending, 0);
    chk("R1 mask", irq_mask, 4'hF);
    chk("R1 redirect", redirect, 0);
  endtask

  task automatic t_boot_rfe();
    retire(16'h0010, 1'b0, 3'd0, 1'b1);
    chk("R9 redirect", redirect, 1);
    chk("R12 target", redirect_pc, 16'h0000);
    chk("R9 commit", commit_ok, 1);
    adv();
    chk("R12 mode", kernel_mode, 0);
    chk("R12 ie", int_enable, 1);
  endtask

  task automatic t_irq_basic();
    irq_lines = 4'b0110; #1;
    chk("R11 idle", redirect, 0);
    adv();
    chk("R2 latch", irq_pending, 4'b0110);
    retire(16'h0200, 1'b0, 3'd0, 1'b0);
    chk("R3 redirect", redirect, 1);
    chk("R3 vector", redirect_pc, VEC);
    chk("R3 held", commit_ok, 0);
    adv();
    chk("R3 cause lowest", cause, 1);
    chk("R3 epc", epc, 16'h0200);
    chk("R8 ie", int_enable, 0);
    chk("R8 kernel", kernel_mode, 1);
    chk("R2 clear", irq_pending, 4'b0100);
    retire(16'h0084, 1'b0, 3'd0, 1'b0);
    chk("R2 no take ie off", redirect, 0);
    chk("R2 commit", commit_ok, 1);
    adv();
    chk("R2 hold", irq_pending, 4'b0100);
    retire(16'h0088, 1'b0, 3'd0, 1'b1);
    chk("R9 target", redirect_pc, 16'h0200);
    adv();
    chk("R9 ie", int_enable, 1);
    chk("R9 mode", kernel_mode, 0);
    retire(16'h0200, 1'b0, 3'd0, 1'b0);
    chk("R3 second", redirect, 1);
    adv();
    chk("R3 cause2", cause, 2);
    chk("R2 empty", irq_pending, 0);
    do_rfe();
  endtask

  task automatic t_mask();
    mask_wr = 1'b1; mask_wdata = 4'h0;
    adv();
    chk("R4 user write ignored", irq_mask, 4'hF);
    retire(16'h0300, 1'b1, 3'd6, 1'b0);
    chk("R6 redirect", redirect, 1);
    chk("R6 commit", commit_ok, 1);
    adv();
    chk("R6 cause", cause, 14);
    chk("R6 epc", epc, 16'h0304);
    mask_wr = 1'b1; mask_wdata = 4'b1110;
    adv();
    chk("R4 kernel write", irq_mask, 4'b1110);
    retire(16'h0090, 1'b0, 3'd0, 1'b1);
    chk("R9 to epc", redirect_pc, 16'h0304);
    adv();
    irq_lines = 4'b0001;
    adv();
    retire(16'h0400, 1'b0, 3'd0, 1'b0);
    chk("R4 masked", redirect, 0);
    adv();
    chk("R4 masked pending", irq_pending, 4'b0001);
    irq_lines = 4'b1000;
    adv();
    retire(16'h0404, 1'b0, 3'd0, 1'b0);
    chk("R4 unmasked taken", redirect, 1);
    adv();
    chk("R4 cause3", cause, 3);
    mask_wr = 1'b1; mask_wdata = 4'hF;
    adv();
    do_rfe();
  endtask

  task automatic t_priority();
    retire(16'h0500, 1'b1, 3'd2, 1'b0);
    chk("R7 redirect", redirect, 1);
    adv();
    chk("R7 sync wins", cause, 10);
    chk("R7 still pending", irq_pending, 4'b0001);
    do_rfe();
    retire(16'h0504, 1'b0, 3'd0, 1'b0);
    adv();
    chk("R3 line0", cause, 0);
    chk("R3 epc0", epc, 16'h0504);
    irq_lines = 4'b1010;
    adv();
    do_rfe();
    retire(16'h0600, 1'b0, 3'd0, 1'b0);
    adv();
    chk("R3 priority", cause, 1);
    chk("R2 rest", irq_pending, 4'b1000);
    do_rfe();
    retire(16'h0604, 1'b0, 3'd0, 1'b0);
    adv();
    chk("R3 line3", cause, 3);
    do_rfe();
  endtask

  task automatic t_sync_kinds();
    for (int k = 0; k < 8; k++) begin
      if (k == 6) continue;
      retire(16'h0700 + 16'(k * 4), 1'b1, 3'(k), 1'b0);
      chk("R5 redirect", redirect, 1);
      chk("R5 held", commit_ok, 0);
      adv();
      chk("R5 cause", cause, (k == 7) ? 8 : 8 + k);
      chk("R5 epc", epc, 16'h0700 + 16'(k * 4));
      do_rfe();
    end
  endtask

  task automatic t_user_rfe();
    retire(16'h0800, 1'b0, 3'd0, 1'b1);
    chk("R10 vector", redirect_pc, VEC);
    chk("R10 held", commit_ok, 0);
    adv();
    chk("R10 cause", cause, 9);
    chk("R10 kernel", kernel_mode, 1);
    chk("R10 epc", epc, 16'h0800);
    do_rfe();
  endtask

  task automatic t_wrap();
    retire(16'hFFFC, 1'b1, 3'd6, 1'b0);
    adv();
    chk("R6 wrap", epc, 16'h0000);
    chk("R6 cause", cause, 14);
    retire(16'h0098, 1'b0, 3'd0, 1'b1);
    chk("R9 wrap target", redirect_pc, 16'h0000);
    adv();
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    t_reset();
    t_boot_rfe();
    t_irq_basic();
    t_mask();
    t_priority();
    t_sync_kinds();
    t_user_rfe();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule